// File: doc/BRIEF.md
# First-Error Status Register with Diagnostic Log

This block records which hardware error sources have fired, and keeps a diagnostic snapshot of the first one. Each of eight error sources has a status bit. A one-cycle pulse on a source sets its bit. Software clears a bit by writing a one to its position; writing a zero leaves the bit as it is. Alongside the status bits sits a log. When the log is armed and a source fires, the log takes that source's 64-bit data word, its 8 check bits and the 3-bit number of the source. It then stays frozen until software has cleared every status bit.

A clear can land in the same cycle as a fresh error on the same bit. In that case the bit stays set, the log is not reloaded, and a separate sticky stale-log flag comes up. The flag tells software that the log does not describe the latest error. The stale flag is also cleared by writing a one: bit 8 of the write word. A clear that covers all eight bits (every bit written with one) therefore raises the stale flag for any error arriving in that cycle.

Top module: `ferr_log_top`

## Requirements
- R1: After synchronous reset, `status`, `stale`, `log_data`, `log_chk` and `log_src` are all zero.
- R2: A pulse on `err_pulse[i]` makes `status[i]` one after the next rising edge. The bit remains one until a clear for bit i is written.
- R3: When `wr_en` is high, a one in `wr_data[i]` (i in 0..7) clears `status[i]` at the next edge. A zero in `wr_data[i]`, or `wr_en` low, leaves `status[i]` unchanged.
- R4: If `wr_data[i]` is written with one in the same cycle that `err_pulse[i]` fires, `status[i]` is one afterwards and `stale` becomes one.
- R5: A clear of bit j together with an error on a different bit k does not raise `stale`. Bit j reads zero and bit k reads one afterwards.
- R6: A write of ones to all of bits 0..7 raises `stale` if any error pulse arrives in that same cycle.
- R7: The log is armed in a cycle when no error collides with a clear and no status bit would remain set after that cycle's clears. If an error arrives while the log is armed, the log loads from the lowest-numbered firing source i. `log_data` takes `err_data[64*i +: 64]`, `log_chk` takes `err_chk[8*i +: 8]` and `log_src` takes i.
- R8: While any status bit stays set through a cycle, the log outputs keep their values, whatever errors arrive.
- R9: Writing a one to `wr_data[8]` with `wr_en` high clears `stale`, unless a collision in the same cycle sets it again, in which case `stale` stays one.
- R10: In a collision cycle (R4 or R6) the log is not loaded, even if the log was armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 9 | Write-one-to-clear mask: bits 0..7 for status, bit 8 for the stale flag |
| err_pulse | input | 8 | One-cycle error pulses, one per source |
| err_data | input | 512 | Capture data, 64 bits per source, source i at bits 64*i upward |
| err_chk | input | 64 | Check bits, 8 per source, source i at bits 8*i upward |
| status | output | 8 | First-error status bits |
| stale | output | 1 | Clear/set collision flag, log not trustworthy |
| log_data | output | 64 | Captured data word |
| log_chk | output | 8 | Captured check bits |
| log_src | output | 3 | Number of the captured source |

## Verification
A wrong status bit appears on `status` one edge after the offending pulse or write. The exposure is sharpest in collision cycles: a design that lets the clear win there shows a zero where a one is due, with `stale` low. A log that opens too early shows up as a changed `log_src` or `log_data` one edge after an error that arrived while another bit was still set. A log that stays frozen when it should load shows the old contents after the first error that follows a full clear. Random mixes of pulses and partial or full clears exercise the arming window from both sides.

// File: rtl/ferr_pkg.sv
package ferr_pkg;
    parameter int ERR_CNT = 8;
    parameter int DATA_W  = 64;
    parameter int CHK_W   = 8;
    localparam int SRC_W  = $clog2(ERR_CNT);
    localparam int WR_W   = ERR_CNT + 1;
    localparam int STALE_BIT = ERR_CNT;

    typedef struct packed {
        logic [SRC_W-1:0]  src;
        logic [CHK_W-1:0]  chk;
        logic [DATA_W-1:0] data;
    } log_entry_t;

    typedef struct packed {
        logic              hit;
        logic [SRC_W-1:0]  idx;
    } pick_t;

    // next value of a set of write-one-to-clear bits with hardware set priority
    function automatic logic [ERR_CNT-1:0] w1c_next(
        input logic [ERR_CNT-1:0] cur,
        input logic [ERR_CNT-1:0] clr,
        input logic [ERR_CNT-1:0] set
    );
        return (cur & ~clr) | set;
    endfunction
endpackage

// File: rtl/ferr_status_bits.sv
module ferr_status_bits
    import ferr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ERR_CNT-1:0] set_vec,
    input  logic [ERR_CNT-1:0] clr_vec,
    input  logic               stale_clr,
    output logic [ERR_CNT-1:0] status_q,
    output logic               stale_q,
    output logic               collide
);
    logic [ERR_CNT-1:0] status_d;
    logic [ERR_CNT-1:0] hit_vec;

    assign status_d = w1c_next(status_q, clr_vec, set_vec);

    genvar gi;
    generate
        for (gi = 0; gi < ERR_CNT; gi++) begin : g_bit
            assign hit_vec[gi] = set_vec[gi] & clr_vec[gi];
            always_ff @(posedge clk) begin
                if (rst) status_q[gi] <= 1'b0;
                else     status_q[gi] <= status_d[gi];
            end
        end
    endgenerate

    assign collide = |hit_vec;

    always_ff @(posedge clk) begin
        if (rst)          stale_q <= 1'b0;
        else if (collide) stale_q <= 1'b1;
        else if (stale_clr) stale_q <= 1'b0;
    end
endmodule

// File: rtl/ferr_prio_pick.sv
module ferr_prio_pick
    import ferr_pkg::*;
(
    input  logic [ERR_CNT-1:0] req,
    output pick_t              pick
);
    always_comb begin
        pick = '0;
        for (int i = ERR_CNT - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick.hit = 1'b1;
                pick.idx = SRC_W'(i);
            end
        end
    end
endmodule

// File: rtl/ferr_log_capture.sv
module ferr_log_capture
    import ferr_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic [SRC_W-1:0]          sel,
    input  logic [ERR_CNT*DATA_W-1:0] src_data,
    input  logic [ERR_CNT*CHK_W-1:0]  src_chk,
    output log_entry_t                entry_q
);
    log_entry_t entry_d;

    always_comb begin
        entry_d.src  = sel;
        entry_d.data = src_data[sel*DATA_W +: DATA_W];
        entry_d.chk  = src_chk[sel*CHK_W +: CHK_W];
    end

    always_ff @(posedge clk) begin
        if (rst)       entry_q <= '0;
        else if (load) entry_q <= entry_d;
    end
endmodule

// File: rtl/ferr_log_top.sv
module ferr_log_top
    import ferr_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [WR_W-1:0]           wr_data,
    input  logic [ERR_CNT-1:0]        err_pulse,
    input  logic [ERR_CNT*DATA_W-1:0] err_data,
    input  logic [ERR_CNT*CHK_W-1:0]  err_chk,
    output logic [ERR_CNT-1:0]        status,
    output logic                      stale,
    output logic [DATA_W-1:0]         log_data,
    output logic [CHK_W-1:0]          log_chk,
    output logic [SRC_W-1:0]          log_src
);
    logic [ERR_CNT-1:0] clr_vec;
    logic               stale_clr;
    logic               collide;
    logic               armed;
    pick_t              pick;
    log_entry_t         entry;

    assign clr_vec   = wr_en ? wr_data[ERR_CNT-1:0] : '0;
    assign stale_clr = wr_en & wr_data[STALE_BIT];

    ferr_status_bits u_bits (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (err_pulse),
        .clr_vec  (clr_vec),
        .stale_clr(stale_clr),
        .status_q (status),
        .stale_q  (stale),
        .collide  (collide)
    );

    ferr_prio_pick u_pick (
        .req (err_pulse),
        .pick(pick)
    );

    // log may load only if nothing survives this cycle's clears and no collision
    assign armed = ((status & ~clr_vec) == '0) && !collide;

    ferr_log_capture u_log (
        .clk     (clk),
        .rst     (rst),
        .load    (armed & pick.hit),
        .sel     (pick.idx),
        .src_data(err_data),
        .src_chk (err_chk),
        .entry_q (entry)
    );

    assign log_data = entry.data;
    assign log_chk  = entry.chk;
    assign log_src  = entry.src;
endmodule

// File: rtl/ferr_log_sva.sv
module ferr_log_sva
    import ferr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [WR_W-1:0]    wr_data,
    input logic [ERR_CNT-1:0] err_pulse,
    input logic [ERR_CNT-1:0] status,
    input logic               stale,
    input logic [DATA_W-1:0]  log_data,
    input logic [SRC_W-1:0]   log_src
);
    logic [ERR_CNT-1:0] wmask;
    assign wmask = wr_en ? wr_data[ERR_CNT-1:0] : '0;

    // R2: a pulsed bit is set after the edge
    a_r2_pulse_sets: assert property (@(posedge clk) disable iff (rst)
        (err_pulse != '0) |=> ((status & $past(err_pulse)) == $past(err_pulse)));

    // R3: bits not written with one never drop
    a_r3_no_spurious_clear: assert property (@(posedge clk) disable iff (rst)
        (status & ~wmask) != '0 |=> ((status & $past(status & ~wmask)) == $past(status & ~wmask)));

    // R4: clear and set on the same bit raises the stale flag
    a_r4_collision_flags: assert property (@(posedge clk) disable iff (rst)
        ((wmask & err_pulse) != '0) |=> stale);

    // R5: without a collision a low stale flag stays low
    a_r5_no_false_stale: assert property (@(posedge clk) disable iff (rst)
        (!stale && ((wmask & err_pulse) == '0)) |=> !stale);

    // R8: the log is frozen while a status bit survives the cycle
    a_r8_log_frozen: assert property (@(posedge clk) disable iff (rst)
        ((status & ~wmask) != '0) |=> ($stable(log_data) && $stable(log_src)));

    // R10: collision cycles never reload the log
    a_r10_no_load_on_collision: assert property (@(posedge clk) disable iff (rst)
        ((wmask & err_pulse) != '0) |=> ($stable(log_data) && $stable(log_src)));
endmodule

bind ferr_log_top ferr_log_sva u_sva (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .err_pulse(err_pulse),
    .status   (status),
    .stale    (stale),
    .log_data (log_data),
    .log_src  (log_src)
);

// File: tb/tb_ferr_log_top.sv
module tb_ferr_log_top;
    import ferr_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic                      clk = 1'b0;
    logic                      rst;
    logic                      wr_en;
    logic [WR_W-1:0]           wr_data;
    logic [ERR_CNT-1:0]        err_pulse;
    logic [ERR_CNT*DATA_W-1:0] err_data;
    logic [ERR_CNT*CHK_W-1:0]  err_chk;
    logic [ERR_CNT-1:0]        status;
    logic                      stale;
    logic [DATA_W-1:0]         log_data;
    logic [CHK_W-1:0]          log_chk;
    logic [SRC_W-1:0]          log_src;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [ERR_CNT-1:0] m_status;
    logic               m_stale;
    logic [DATA_W-1:0]  m_data;
    logic [CHK_W-1:0]   m_chk;
    logic [SRC_W-1:0]   m_src;

    always #(CLK_PERIOD/2) clk = ~clk;

    ferr_log_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .err_pulse(err_pulse), .err_data(err_data), .err_chk(err_chk),
        .status(status), .stale(stale), .log_data(log_data),
        .log_chk(log_chk), .log_src(log_src)
    );

    function automatic int lowest(input logic [ERR_CNT-1:0] v);
        for (int i = 0; i < ERR_CNT; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "status", 64'(status), 64'(m_status));
        chk(tag, "stale", 64'(stale), 64'(m_stale));
        chk(tag, "log_data", log_data, m_data);
        chk(tag, "log_chk", 64'(log_chk), 64'(m_chk));
        chk(tag, "log_src", 64'(log_src), 64'(m_src));
    endtask

    task automatic fill_sources();
        for (int i = 0; i < ERR_CNT; i++) begin
            err_data[i*DATA_W +: DATA_W] = {$urandom, $urandom};
            err_chk[i*CHK_W +: CHK_W]    = CHK_W'($urandom);
        end
    endtask

    // drive one cycle, update the model from the requirements, check after the edge
    task automatic step(input logic [ERR_CNT-1:0] p, input logic we, input logic [WR_W-1:0] wd, input string tag);
        logic [ERR_CNT-1:0] clr;
        logic coll, armed;
        int k;
        @(negedge clk);
        fill_sources();
        err_pulse = p; wr_en = we; wr_data = wd;
        clr   = we ? wd[ERR_CNT-1:0] : '0;
        coll  = |(p & clr);
        armed = ((m_status & ~clr) == '0) && !coll;
        k     = lowest(p);
        if (armed && k >= 0) begin
            m_data = err_data[k*DATA_W +: DATA_W];
            m_chk  = err_chk[k*CHK_W +: CHK_W];
            m_src  = SRC_W'(k);
        end
        m_status = (m_status & ~clr) | p;
        if (coll) m_stale = 1'b1;
        else if (we && wd[STALE_BIT]) m_stale = 1'b0;
        @(posedge clk);
        #1;
        compare(tag);
        err_pulse = '0; wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; err_pulse = '0;
        err_data = '0; err_chk = '0;
        m_status = '0; m_stale = 1'b0; m_data = '0; m_chk = '0; m_src = '0;
        repeat (3) @(posedge clk);
        #1;
        compare("R1");
        @(negedge clk);
        rst = 1'b0;

        step(8'h04, 1'b0, 9'h000, "R7");   // first error, log loads from source 2
        step(8'h20, 1'b0, 9'h000, "R8");   // second error, log frozen
        step(8'h00, 1'b1, 9'h000, "R3");   // write of zeros has no effect
        step(8'h00, 1'b0, 9'h0FF, "R3");   // wr_en low has no effect
        step(8'h00, 1'b1, 9'h004, "R3");   // clear bit 2 only
        step(8'h20, 1'b1, 9'h020, "R4");   // clear and set bit 5 together
        step(8'h00, 1'b0, 9'h000, "R10");  // log untouched by the collision
        step(8'h00, 1'b1, 9'h100, "R9");   // clear stale flag
        step(8'h40, 1'b1, 9'h008, "R5");   // clear bit 3, error on bit 6
        step(8'h00, 1'b1, 9'h060, "R3");   // empty status
        step(8'h92, 1'b0, 9'h000, "R7");   // several sources, lowest (1) wins
        step(8'h00, 1'b1, 9'h0FF, "R3");
        step(8'h01, 1'b1, 9'h0FF, "R6");   // full clear plus any error
        step(8'h08, 1'b1, 9'h1FF, "R9");   // stale clear loses to collision
        step(8'h00, 1'b1, 9'h1FF, "R9");
        step(8'h10, 1'b1, 9'h000, "R2");   // armed again after full clear
        step(8'h00, 1'b0, 9'h000, "R2");

        for (int n = 0; n < 600; n++) begin
            logic [ERR_CNT-1:0] p;
            logic we;
            logic [WR_W-1:0] wd;
            p  = ERR_CNT'($urandom & $urandom & $urandom);
            we = ($urandom % 3) == 0;
            wd = (($urandom % 5) == 0) ? '1 : WR_W'($urandom);
            step(p, we, wd, "R2");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule